// File: doc/BRIEF.md
# Full-Bridge Gate Timing Sequencer

This block sequences the six gate-drive signals of a phase-shifted full-bridge power stage: two upper switches, two lower switches and two output synchronous rectifiers. Time is measured in cycles of the block clock. One half of the switching period lasts `HALF_CYC` cycles. The upper switches alternate each half-period at an exact 50% duty. In each half, one lower switch (the one diagonal to the conducting upper switch) is pulsed. Its turn-on is held back by a resonant delay. Its turn-off comes from a digital current-trip input, or at a dead-time margin before the half ends if no trip arrives.

Each trip input is the output of an external current comparator and is assumed to be already synchronous to the clock. A trip arriving in the first few cycles of a lower pulse is masked by a blanking window, so switching spikes cannot end the pulse early. A flag reports when that window is open. The resonant delay, dead time and blanking length are sampled only when a switching period begins. Each output is a flip-flop.

Top module: `fb_gate_seq`

## Requirements
- R1: While reset is asserted or the enable input is low, all six gate outputs and the blanking flag are low at the next clock edge.
- R2: At the first clock edge with enable high, `upper1_o` goes high. After that, `upper1_o` and `upper2_o` alternate, each high for exactly `HALF_CYC` cycles and never both high.
- R3: `lower2_o` is used only in halves where `upper1_o` is high, and `lower1_o` only in halves where `upper2_o` is high. A lower switch turns on at cycle index `rd` of its half, where index 0 is the first cycle of the half. A resonant-delay setting of 0 is treated as 1.
- R4: With no accepted trip, the lower switch turns off at cycle index `HALF_CYC - dt` of its half, which limits the maximum duty. A dead-time setting of 0 is treated as 1, and a setting above `HALF_CYC-1` is treated as `HALF_CYC-1`. When `rd >= HALF_CYC - dt`, the lower switch stays off.
- R5: When a trip input is high at a clock edge while its lower switch is on and the blanking window is closed, that lower switch is low after this edge. It stays low for the rest of the half.
- R6: For the first `leb` cycles of each lower pulse, its trip input is ignored and `blank_o` is high. With `leb = 0`, a trip can end a pulse after one cycle.
- R7: A trip input is ignored while its lower switch is off. This includes the dead-time interval and the opposite half, so the next pulse of that switch starts and ends normally.
- R8: An upper switch and the lower switch on the same side (`upper1_o`/`lower1_o`, `upper2_o`/`lower2_o`) are never high together. At least one cycle separates them in each direction.
- R9: `sync1_o` is high exactly when running, `lower2_o` is low and the cycle lies outside the dead-time interval (index `>= HALF_CYC - dt`). `sync2_o` follows the same rule with `lower1_o`.
- R10: The delay settings take effect only at the start of a switching period, which is the edge where `upper1_o` rises. A change in mid-period leaves the rest of that period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Switching enable |
| trip1_i | input | 1 | Current trip for lower switch 1 (synchronous) |
| trip2_i | input | 1 | Current trip for lower switch 2 (synchronous) |
| res_dly_i | input | CW | Resonant delay in cycles (CW = clog2(HALF_CYC)) |
| dead_i | input | CW | Dead time in cycles |
| blank_len_i | input | CW | Blanking length in cycles |
| upper1_o | output | 1 | Upper switch, side 1 |
| upper2_o | output | 1 | Upper switch, side 2 |
| lower1_o | output | 1 | Lower switch, side 1 |
| lower2_o | output | 1 | Lower switch, side 2 |
| sync1_o | output | 1 | Synchronous rectifier 1 gate |
| sync2_o | output | 1 | Synchronous rectifier 2 gate |
| blank_o | output | 1 | A lower pulse is in its blanking window |

## Verification
The bench holds a trip high for the whole run. Every lower pulse must then be exactly one cycle longer than the blanking length. A design that let the trip through during blanking would give runt pulses, and one that mishandled a zero blanking length would give a wrong width. A trip is also applied during the dead time and at the very start of a half. A design that accepted trips while its switch is off would then skip the next pulse entirely. A dead-time change in mid-period has to leave the current period alone, and out-of-range settings have to be clamped. A wrong capture point or missing clamps would shorten a dead time or drive a lower switch against its upper switch.

// File: rtl/fbg_pkg.sv
// Shared definitions for the full-bridge gate sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package fbg_pkg;

    // Which half of the switching period is running.
    typedef enum logic {
        HALF_A = 1'b0,   // upper1 on, lower2 may pulse
        HALF_B = 1'b1    // upper2 on, lower1 may pulse
    } half_e;

    // Gate drive bundle, grouped for the output register.
    typedef struct packed {
        logic up1;
        logic up2;
        logic lo1;
        logic lo2;
        logic sr1;
        logic sr2;
        logic blk;
    } gates_t;

endpackage

// File: rtl/fbg_period_timer.sv
// Half-period timer. Counts HALF_CYC cycles per half and toggles the half
// at each wrap. It exposes next-state values so that the output flops see
// the same edge as the timer. cap_d flags the edge that begins a period.
// Assumes: HALF_CYC >= 4. en_i is synchronous.
module fbg_period_timer
    import fbg_pkg::*;
#(
    parameter int HALF_CYC = 40,
    parameter int CW       = $clog2(HALF_CYC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    output logic          run_d,
    output half_e         half_d,
    output logic [CW-1:0] cnt_d,
    output logic          cap_d
);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic          run_q;
    half_e         half_q;
    logic [CW-1:0] cnt_q;

    // Next state: hold idle when disabled, restart in half A, else count.
    always_comb begin
        run_d  = run_q;
        half_d = half_q;
        cnt_d  = cnt_q;
        cap_d  = 1'b0;
        if (!en_i) begin
            run_d  = 1'b0;
            half_d = HALF_A;
            cnt_d  = '0;
        end else if (!run_q) begin
            run_d  = 1'b1;
            half_d = HALF_A;
            cnt_d  = '0;
            cap_d  = 1'b1;
        end else if (cnt_q == LAST) begin
            cnt_d  = '0;
            half_d = (half_q == HALF_A) ? HALF_B : HALF_A;
            cap_d  = (half_q == HALF_B);
        end else begin
            cnt_d  = cnt_q + 1'b1;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            half_q <= HALF_A;
            cnt_q  <= '0;
        end else begin
            run_q  <= run_d;
            half_q <= half_d;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/fbg_cfg_latch.sv
// Timing settings latch. It clamps and captures the three settings on a
// period-start edge, and presents the value in force for that edge
// (the new one when capturing) to the decode logic.
// Assumes: cap_i is high only on period-start edges.
module fbg_cfg_latch #(
    parameter int HALF_CYC = 40,
    parameter int CW       = $clog2(HALF_CYC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [CW-1:0] rd_i,
    input  logic [CW-1:0] dt_i,
    input  logic [CW-1:0] leb_i,
    output logic [CW-1:0] rd_o,
    output logic [CW-1:0] dt_o,
    output logic [CW-1:0] leb_o
);
    localparam logic [CW-1:0] DT_MAX = CW'(HALF_CYC - 1);

    logic [CW-1:0] rd_q, dt_q, leb_q;
    logic [CW-1:0] rd_c, dt_c;

    // Clamp: delay and dead time at least one cycle, dead time below a half.
    always_comb begin
        rd_c = (rd_i == '0) ? CW'(1) : rd_i;
        if (dt_i == '0)         dt_c = CW'(1);
        else if (dt_i > DT_MAX) dt_c = DT_MAX;
        else                    dt_c = dt_i;
    end

    // Values in force for the current edge.
    always_comb begin
        rd_o  = cap_i ? rd_c  : rd_q;
        dt_o  = cap_i ? dt_c  : dt_q;
        leb_o = cap_i ? leb_i : leb_q;
    end

    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= CW'(1);
            dt_q  <= CW'(1);
            leb_q <= '0;
        end else begin
            rd_q  <= rd_o;
            dt_q  <= dt_o;
            leb_q <= leb_o;
        end
    end
endmodule

// File: rtl/fbg_lower_leg.sv
// One lower switch. It is on from index rd to index HALF_CYC-dt of its
// active half. An accepted trip ends the pulse for the rest of the half.
// Trips are accepted only while the switch is on and the blanking count
// has expired.
// Assumes: trip_i is synchronous. rd >= 1 (ensured by the settings latch).
module fbg_lower_leg
    import fbg_pkg::*;
#(
    parameter int    HALF_CYC = 40,
    parameter int    CW       = $clog2(HALF_CYC),
    parameter half_e ACT_HALF = HALF_A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_d,
    input  half_e         half_d,
    input  logic [CW-1:0] cnt_d,
    input  logic [CW-1:0] rd_i,
    input  logic [CW-1:0] dt_i,
    input  logic [CW-1:0] leb_i,
    input  logic          trip_i,
    output logic          lo_d,
    output logic          blank_d
);
    localparam logic [CW:0] HALF_X = (CW+1)'(HALF_CYC);

    logic          lo_q, cut_q, cut_d, active_d, win_d, trip_ok;
    logic [CW-1:0] blk_q, blk_d;

    // Window test and trip acceptance for the coming cycle.
    always_comb begin
        active_d = run_d && (half_d == ACT_HALF);
        win_d    = active_d && (cnt_d >= rd_i) &&
                   (({1'b0, cnt_d} + {1'b0, dt_i}) < HALF_X);
        trip_ok  = lo_q && (blk_q == '0) && trip_i;
        cut_d    = active_d && (cut_q || trip_ok);
        lo_d     = win_d && !cut_d;
    end

    // Blanking countdown, loaded at the rising edge of the pulse.
    always_comb begin
        if (!lo_d)              blk_d = '0;
        else if (!lo_q)         blk_d = leb_i;
        else if (blk_q != '0)   blk_d = blk_q - 1'b1;
        else                    blk_d = '0;
        blank_d = (blk_d != '0);
    end

    // Leg state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= 1'b0;
            cut_q <= 1'b0;
            blk_q <= '0;
        end else begin
            lo_q  <= lo_d;
            cut_q <= cut_d;
            blk_q <= blk_d;
        end
    end
endmodule

// File: rtl/fb_gate_seq.sv
// Full-bridge gate sequencer top. Combines the half-period timer, the
// settings latch and two lower legs, derives the upper and rectifier
// gates, and registers all outputs from the next-state decode.
// Assumes: trips and enable are synchronous to clk. HALF_CYC >= 4.
module fb_gate_seq
    import fbg_pkg::*;
#(
    parameter int HALF_CYC = 40,
    parameter int CW       = $clog2(HALF_CYC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          trip1_i,
    input  logic          trip2_i,
    input  logic [CW-1:0] res_dly_i,
    input  logic [CW-1:0] dead_i,
    input  logic [CW-1:0] blank_len_i,
    output logic          upper1_o,
    output logic          upper2_o,
    output logic          lower1_o,
    output logic          lower2_o,
    output logic          sync1_o,
    output logic          sync2_o,
    output logic          blank_o
);
    localparam logic [CW:0] HALF_X = (CW+1)'(HALF_CYC);

    logic          run_d, cap_d;
    half_e         half_d;
    logic [CW-1:0] cnt_d, rd_v, dt_v, leb_v;
    logic [1:0]    lo_d, blank_d, trip_v;
    gates_t        g_d, g_q;

    fbg_period_timer #(.HALF_CYC(HALF_CYC), .CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .en_i(en_i),
        .run_d(run_d), .half_d(half_d), .cnt_d(cnt_d), .cap_d(cap_d)
    );

    fbg_cfg_latch #(.HALF_CYC(HALF_CYC), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cap_i(cap_d),
        .rd_i(res_dly_i), .dt_i(dead_i), .leb_i(blank_len_i),
        .rd_o(rd_v), .dt_o(dt_v), .leb_o(leb_v)
    );

    assign trip_v = {trip2_i, trip1_i};

    // Leg 0 is lower1 (pulses in half B); leg 1 is lower2 (pulses in half A).
    for (genvar i = 0; i < 2; i++) begin : g_leg
        fbg_lower_leg #(
            .HALF_CYC(HALF_CYC), .CW(CW),
            .ACT_HALF((i == 0) ? HALF_B : HALF_A)
        ) u_leg (
            .clk(clk), .rst_n(rst_n), .run_d(run_d), .half_d(half_d),
            .cnt_d(cnt_d), .rd_i(rd_v), .dt_i(dt_v), .leb_i(leb_v),
            .trip_i(trip_v[i]), .lo_d(lo_d[i]), .blank_d(blank_d[i])
        );
    end

    // Gate decode for the coming cycle.
    always_comb begin
        logic dead;
        dead    = (({1'b0, cnt_d} + {1'b0, dt_v}) >= HALF_X);
        g_d.up1 = run_d && (half_d == HALF_A);
        g_d.up2 = run_d && (half_d == HALF_B);
        g_d.lo1 = lo_d[0];
        g_d.lo2 = lo_d[1];
        g_d.sr1 = run_d && !lo_d[1] && !dead;
        g_d.sr2 = run_d && !lo_d[0] && !dead;
        g_d.blk = |blank_d;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign upper1_o = g_q.up1;
    assign upper2_o = g_q.up2;
    assign lower1_o = g_q.lo1;
    assign lower2_o = g_q.lo2;
    assign sync1_o  = g_q.sr1;
    assign sync2_o  = g_q.sr2;
    assign blank_o  = g_q.blk;
endmodule

// File: rtl/fbg_gate_checker.sv
// Protocol checker for fb_gate_seq, attached by bind. Watches only ports.
module fbg_gate_checker (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic upper1_o,
    input logic upper2_o,
    input logic lower1_o,
    input logic lower2_o,
    input logic sync1_o,
    input logic sync2_o,
    input logic blank_o
);
    assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !(upper1_o || upper2_o || lower1_o || lower2_o ||
                    sync1_o || sync2_o || blank_o));

    assert_uppers_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upper1_o |-> !upper2_o);

    assert_upper2_after_upper1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upper2_o) |-> $past(upper1_o));

    assert_resonant_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lower2_o) |-> !$past(upper2_o));

    assert_dead_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upper1_o) |-> !$past(lower1_o));

    assert_no_shoot_side1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(upper1_o && lower1_o));

    assert_no_shoot_side2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(upper2_o && lower2_o));

    assert_sync1_vs_lower2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lower2_o |-> !sync1_o);

    assert_sync2_vs_lower1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lower1_o |-> !sync2_o);

    assert_lower2_off_in_half_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upper2_o && !lower2_o) |=> !lower2_o);
endmodule

bind fb_gate_seq fbg_gate_checker u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .upper1_o(upper1_o), .upper2_o(upper2_o),
    .lower1_o(lower1_o), .lower2_o(lower2_o),
    .sync1_o(sync1_o), .sync2_o(sync2_o), .blank_o(blank_o)
);

// File: tb/tb_fb_gate_seq.sv
`timescale 1ns/1ps
module tb_fb_gate_seq;
    localparam int H    = 40;
    localparam int CW   = $clog2(H);
    localparam int MAXN = 200;
    localparam int NOCHG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0, en = 1'b0, trip1 = 1'b0, trip2 = 1'b0;
    logic [CW-1:0] rd_s = '0, dt_s = '0, leb_s = '0;
    logic u1, u2, l1, l2, s1, s2, blk;

    int errors = 0, checks = 0, overlap = 0;
    logic [6:0] tr [MAXN];
    logic [6:0] ex [MAXN];
    logic       tv1 [MAXN];
    logic       tv2 [MAXN];
    int         edt [MAXN];

    always #2 clk = ~clk;

    fb_gate_seq #(.HALF_CYC(H)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .trip1_i(trip1), .trip2_i(trip2),
        .res_dly_i(rd_s), .dead_i(dt_s), .blank_len_i(leb_s),
        .upper1_o(u1), .upper2_o(u2), .lower1_o(l1), .lower2_o(l2),
        .sync1_o(s1), .sync2_o(s2), .blank_o(blk)
    );

    // R8 same-side overlap monitor
    always @(negedge clk) if ((u1 && l1) || (u2 && l2)) overlap++;

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish got=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic int clamp_rd(int v); return (v == 0) ? 1 : v; endfunction
    function automatic int clamp_dt(int v);
        if (v == 0) return 1;
        if (v > H - 1) return H - 1;
        return v;
    endfunction

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // Compare masked trace bits; one check per call.
    task automatic cmp(string req, string what, logic [6:0] mask, int n);
        checks++;
        for (int k = 0; k < n; k++) begin
            if (((tr[k] ^ ex[k]) & mask) != 0) begin
                errors++;
                $display("FAIL %s %s at sample %0d: got=%b expected=%b",
                         req, what, k, tr[k] & mask, ex[k] & mask);
                return;
            end
        end
    endtask

    // Expected trace from the requirements. Bits: 0 u1,1 u2,2 l1,3 l2,4 s1,5 s2,6 blank.
    task automatic build(int n, int rda, int dta, int leba, int rdb, int dtb, int lebb, int chg);
        for (int k = 0; k < n; k++) begin
            int h = k / H, c = k % H;
            bit useb = (2 * H * (h / 2)) >= chg;
            int rd = clamp_rd(useb ? rdb : rda);
            int dt = clamp_dt(useb ? dtb : dta);
            int lb = useb ? lebb : leba;
            bit win = (c >= rd) && (c < H - dt);
            logic [6:0] e = '0;
            e[0] = (h % 2 == 0);
            e[1] = !e[0];
            e[2] = e[1] && win;
            e[3] = e[0] && win;
            e[6] = win && (c < rd + lb);
            edt[k] = dt;
            ex[k] = e;
        end
    endtask

    task automatic fix_sync(int n);
        for (int k = 0; k < n; k++) begin
            bit dead = (k % H) >= H - edt[k];
            ex[k][4] = !ex[k][3] && !dead;
            ex[k][5] = !ex[k][2] && !dead;
        end
    endtask

    task automatic prepare(int rd, int dt, int leb);
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; trip1 = 1'b0; trip2 = 1'b0;
        rd_s = CW'(rd); dt_s = CW'(dt); leb_s = CW'(leb);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < MAXN; k++) begin tv1[k] = 1'b0; tv2[k] = 1'b0; end
    endtask

    // Raise enable at a negedge and record n samples, one per edge.
    task automatic run_trace(int n);
        en = 1'b1;
        for (int k = 0; k < n; k++) begin
            trip1 = tv1[k]; trip2 = tv2[k];
            @(posedge clk);
            @(negedge clk);
            tr[k] = {blk, s2, s1, l2, l1, u2, u1};
        end
        trip1 = 1'b0; trip2 = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; en = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "outputs in reset", {blk, s2, s1, l2, l1, u2, u1}, 0);
        rst_n = 1'b1; en = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "outputs while disabled", {blk, s2, s1, l2, l1, u2, u1}, 0);
    endtask

    task automatic t_basic;
        prepare(3, 4, 2);
        run_trace(4 * H);
        build(4 * H, 3, 4, 2, 3, 4, 2, NOCHG); fix_sync(4 * H);
        check("R2", "upper1 on first edge", tr[0][0], 1);
        cmp("R2", "upper 50% pattern", 7'b0000011, 4 * H);
        cmp("R3", "lower leading edges", 7'b0001100, 4 * H);
        cmp("R9", "sync gates", 7'b0110000, 4 * H);
        cmp("R6", "blank flag no trip", 7'b1000000, 4 * H);
    endtask

    task automatic t_trip_const;
        prepare(5, 3, 4);
        for (int k = 0; k < MAXN; k++) tv2[k] = 1'b1;
        run_trace(4 * H);
        build(4 * H, 5, 3, 4, 5, 3, 4, NOCHG);
        for (int k = 0; k < 4 * H; k++) if ((k % H) >= 5 + 4 + 1) ex[k][3] = 1'b0;
        fix_sync(4 * H);
        cmp("R5", "lower2 ends after blanking", 7'b0001100, 4 * H);
        cmp("R6", "blank window with trip", 7'b1000000, 4 * H);
        cmp("R9", "sync with tripped pulse", 7'b0110000, 4 * H);
    endtask

    task automatic t_leb_zero;
        prepare(2, 3, 0);
        for (int k = 0; k < MAXN; k++) tv1[k] = 1'b1;
        run_trace(4 * H);
        build(4 * H, 2, 3, 0, 2, 3, 0, NOCHG);
        for (int k = 0; k < 4 * H; k++) if ((k % H) >= 3) ex[k][2] = 1'b0;
        fix_sync(4 * H);
        cmp("R6", "zero blanking one-cycle pulse", 7'b1001100, 4 * H);
    endtask

    task automatic t_trip_pulse;
        prepare(3, 4, 2);
        tv2[13] = 1'b1;
        for (int k = 37; k <= 82; k++) tv2[k] = 1'b1;
        run_trace(3 * H);
        build(3 * H, 3, 4, 2, 3, 4, 2, NOCHG);
        for (int k = 13; k < H; k++) ex[k][3] = 1'b0;
        fix_sync(3 * H);
        cmp("R5", "mid-pulse trip ends lower2", 7'b0001000, H);
        cmp("R7", "trip while off ignored", 7'b0001100, 3 * H);
    endtask

    task automatic t_cfg_change;
        prepare(3, 4, 2);
        run_trace(50);
        rd_s = CW'(6); dt_s = CW'(10);
        for (int k = 0; k < MAXN; k++) begin tv1[k] = 1'b0; tv2[k] = 1'b0; end
        for (int k = 50; k < 4 * H; k++) begin
            trip1 = 1'b0; trip2 = 1'b0;
            @(posedge clk);
            @(negedge clk);
            tr[k] = {blk, s2, s1, l2, l1, u2, u1};
        end
        build(4 * H, 3, 4, 2, 6, 10, 2, 50); fix_sync(4 * H);
        cmp("R10", "settings held to period start", 7'b1111111, 4 * H);
    endtask

    task automatic t_clamp;
        prepare(0, 0, 1);
        run_trace(2 * H);
        build(2 * H, 0, 0, 1, 0, 0, 1, NOCHG); fix_sync(2 * H);
        cmp("R3", "zero delay clamped to one", 7'b0001100, 2 * H);
        cmp("R4", "zero dead time clamped", 7'b0111100, 2 * H);
        prepare(2, 50, 1);
        run_trace(2 * H);
        build(2 * H, 2, 50, 1, 2, 50, 1, NOCHG); fix_sync(2 * H);
        cmp("R4", "large dead time suppresses lowers", 7'b1111111, 2 * H);
    endtask

    task automatic t_disable;
        prepare(3, 4, 2);
        run_trace(H + 10);
        en = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", "outputs after disable edge", {blk, s2, s1, l2, l1, u2, u1}, 0);
        run_trace(3);
        check("R2", "restart with upper1", {tr[0][1], tr[0][0]}, 1);
    endtask

    initial begin
        t_reset;
        t_basic;
        t_trip_const;
        t_leb_zero;
        t_trip_pulse;
        t_cfg_change;
        t_clamp;
        t_disable;
        check("R8", "same-side overlap cycles", overlap, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule